// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a free-running nanosecond count for network time stamping. On every enabled reference clock edge it adds a programmed step to the count. The step is the reference clock period in nanoseconds, rounded to the nearest integer, so a 40 MHz clock uses a step of 25. To trim the frequency, software programs a correction period and a correction step: once every correction period the correction step is added in place of the nominal one.

Software reaches the block through a simple synchronous register port with a combinational read path. It can load the count directly and take a snapshot of the running count through a self-clearing capture bit. It can make the count roll over at one second and raise a sticky event on each rollover. To step time backward, it arms an early restart at a compare value. The seconds count is kept by software from the rollover events.

Top module: `ptp_ns_timer`

Register word addresses: 0 control, 1 time, 2 restart compare, 3 correction period, 4 step, 5 status. Control bits: 0 run, 2 restart arm, 3 restart allow, 4 event interrupt enable, 5 one-second rollover, 11 capture.

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While control bit 0 is set, the count grows by the nominal step (step register bits [6:0]) on each clock.
- R3: With a nonzero correction period N, every Nth running clock adds the correction step (step register bits [14:8]) instead of the nominal step. A period of zero never uses the correction step.
- R4: While control bit 0 is clear, the count and the correction counter hold their values, and register writes still take effect.
- R5: A write to the time register (address 1) loads the count on that clock edge.
- R6: Writing 1 to control bit 11 latches the count one clock later into the value read from address 1. The bit then reads 0 again. Reads of address 1 return the snapshot, never the live count.
- R7: With control bit 5 set, a step that would reach or pass 10^9 yields count + step − 10^9 and sets status bit 15.
- R8: With control bit 5 clear, the count wraps modulo 2^32 and status bit 15 is not set.
- R9: With control bits 2 and 3 set, a step that takes the count from below the compare value (address 2) to or past it restarts the count at zero. Control bit 2 then clears itself and status bit 15 is set.
- R10: Status bit 15 stays set until 1 is written to it at address 5; writing 0 leaves it set. `irq` equals status bit 15 AND control bit 4.
- R11: A time-register write takes priority over stepping, rollover and restart in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register word address for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data of the register at `addr` |
| irq | output | 1 | Rollover/restart event interrupt |

## Verification
The counter is run with a plain step, and then with correction periods of 4 and 0. This tells apart whether the substitute step lands on the right clock or is never used. Loads just under 10^9 and just under 2^32 are run with rollover on and off, which shows the two wrap paths apart and shows whether the event bit is set. A restart compare reached from below is checked against the same setup with the count already past the compare. A load issued while running shows that loading wins over stepping. Reads of the time register between captures show that the snapshot is returned and not the live count.

// File: rtl/ptp_ns_timer_pkg.sv
package ptp_ns_timer_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_TIME   = 3'd1;
  localparam logic [ADDR_W-1:0] A_OFFSET = 3'd2;
  localparam logic [ADDR_W-1:0] A_CORR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STEP   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

  localparam int B_RUN      = 0;
  localparam int B_OFF_ARM  = 2;
  localparam int B_OFF_RST  = 3;
  localparam int B_EVT_IRQ  = 4;
  localparam int B_SEC_WRAP = 5;
  localparam int B_CAPTURE  = 11;
  localparam int B_EVT      = 15;
  localparam int CORR_LSB   = 8;

  typedef struct packed {
    logic countEn;
    logic offArm;
    logic secWrap;
    logic capReq;
    logic loadTime;
  } strb_t;
endpackage

// File: rtl/ptp_ns_timer_dp.sv
module ptp_ns_timer_dp
  import ptp_ns_timer_pkg::*;
#(
  parameter int TIME_W  = 32,
  parameter int INC_W   = 7,
  parameter int CORR_W  = 32,
  parameter int WRAP_NS = 1_000_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [TIME_W-1:0] loadVal,
  input  logic [TIME_W-1:0] offsetVal,
  input  logic [CORR_W-1:0] corrPeriod,
  input  logic [INC_W-1:0]  incNom,
  input  logic [INC_W-1:0]  incCorr,
  output logic              hitOffset,
  output logic              hitWrap,
  output logic [TIME_W-1:0] snapshot
);
  localparam logic [TIME_W:0]   WRAP_WIDE = (TIME_W+1)'(WRAP_NS);
  localparam logic [TIME_W-1:0] WRAP_T    = TIME_W'(WRAP_NS);

  logic [TIME_W-1:0] cnt;
  logic [CORR_W-1:0] corrCnt;
  logic              useCorr;
  logic [INC_W-1:0]  stepInc;
  logic [TIME_W:0]   sumWide;
  logic [TIME_W-1:0] sumLo;

  always_comb begin
    useCorr   = (corrPeriod != '0) && (corrCnt >= corrPeriod - CORR_W'(1));
    stepInc   = useCorr ? incCorr : incNom;
    sumLo     = cnt + TIME_W'(stepInc);
    sumWide   = {1'b0, cnt} + (TIME_W+1)'(stepInc);
    hitOffset = strb.countEn && strb.offArm && !strb.loadTime &&
                (cnt < offsetVal) && (sumWide >= {1'b0, offsetVal});
    hitWrap   = strb.countEn && strb.secWrap && !strb.loadTime && !hitOffset &&
                (sumWide >= WRAP_WIDE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      corrCnt  <= '0;
      snapshot <= '0;
    end else begin
      if (strb.loadTime)      cnt <= loadVal;
      else if (hitOffset)     cnt <= '0;
      else if (hitWrap)       cnt <= sumLo - WRAP_T;
      else if (strb.countEn)  cnt <= sumLo;

      if (strb.countEn) begin
        if (useCorr || corrPeriod == '0) corrCnt <= '0;
        else                             corrCnt <= corrCnt + CORR_W'(1);
      end

      if (strb.capReq) snapshot <= cnt;
    end
  end

  // R4: a stopped counter keeps its value unless loaded
  p_hold_when_stopped_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countEn && !strb.loadTime) |=> $stable(cnt));

  // R7: with rollover on, a count below one second stays below it
  p_below_second_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && strb.secWrap && !strb.loadTime && ({1'b0, cnt} < WRAP_WIDE))
      |=> ({1'b0, cnt} < WRAP_WIDE));

  // R5 / R11: a load wins over everything else
  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTime |=> (cnt == $past(loadVal)));

  // R6: snapshot takes the count of the request cycle
  p_capture_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.capReq |=> (snapshot == $past(cnt)));
endmodule

// File: rtl/ptp_ns_timer_ctrl.sv
module ptp_ns_timer_ctrl
  import ptp_ns_timer_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int INC_W  = 7,
  parameter int CORR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output strb_t             strb,
  output logic [TIME_W-1:0] loadVal,
  output logic [TIME_W-1:0] offsetVal,
  output logic [CORR_W-1:0] corrPeriod,
  output logic [INC_W-1:0]  incNom,
  output logic [INC_W-1:0]  incCorr,
  input  logic              hitOffset,
  input  logic              hitWrap,
  input  logic [TIME_W-1:0] snapshot
);
  logic runBit, offArmBit, offRstBit, evtIrqBit, secWrapBit, capBit, evtBit;
  logic wrCtrl, wrStat;

  assign wrCtrl = wrEn && (addr == A_CTRL);
  assign wrStat = wrEn && (addr == A_STAT);

  always_comb begin
    strb.countEn  = runBit;
    strb.offArm   = offArmBit && offRstBit;
    strb.secWrap  = secWrapBit;
    strb.capReq   = capBit;
    strb.loadTime = wrEn && (addr == A_TIME);
    loadVal       = wrData[TIME_W-1:0];
    irq           = evtBit && evtIrqBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit <= 1'b0; offArmBit <= 1'b0; offRstBit <= 1'b0;
      evtIrqBit <= 1'b0; secWrapBit <= 1'b0; capBit <= 1'b0;
      evtBit <= 1'b0;
      offsetVal <= '0; corrPeriod <= '0; incNom <= '0; incCorr <= '0;
    end else begin
      capBit <= wrCtrl && wrData[B_CAPTURE];
      if (wrCtrl) begin
        runBit     <= wrData[B_RUN];
        offArmBit  <= wrData[B_OFF_ARM];
        offRstBit  <= wrData[B_OFF_RST];
        evtIrqBit  <= wrData[B_EVT_IRQ];
        secWrapBit <= wrData[B_SEC_WRAP];
      end else if (hitOffset) begin
        offArmBit  <= 1'b0;
      end
      if (hitOffset || hitWrap)          evtBit <= 1'b1;
      else if (wrStat && wrData[B_EVT])  evtBit <= 1'b0;
      if (wrEn && addr == A_OFFSET) offsetVal  <= wrData[TIME_W-1:0];
      if (wrEn && addr == A_CORR)   corrPeriod <= wrData[CORR_W-1:0];
      if (wrEn && addr == A_STEP) begin
        incNom  <= wrData[INC_W-1:0];
        incCorr <= wrData[CORR_LSB +: INC_W];
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL: begin
        rdData[B_RUN]      = runBit;
        rdData[B_OFF_ARM]  = offArmBit;
        rdData[B_OFF_RST]  = offRstBit;
        rdData[B_EVT_IRQ]  = evtIrqBit;
        rdData[B_SEC_WRAP] = secWrapBit;
        rdData[B_CAPTURE]  = capBit;
      end
      A_TIME:   rdData[TIME_W-1:0] = snapshot;
      A_OFFSET: rdData[TIME_W-1:0] = offsetVal;
      A_CORR:   rdData[CORR_W-1:0] = corrPeriod;
      A_STEP: begin
        rdData[INC_W-1:0]       = incNom;
        rdData[CORR_LSB +: INC_W] = incCorr;
      end
      A_STAT:   rdData[B_EVT] = evtBit;
      default:  rdData = '0;
    endcase
  end

  // R6: the capture request lasts a single clock
  p_capture_selfclear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (capBit && !(wrCtrl && wrData[B_CAPTURE])) |=> !capBit);

  // R10: the event bit only drops on a write of 1
  p_event_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (evtBit && !(wrStat && wrData[B_EVT])) |=> evtBit);

  // R9: an early restart disarms itself
  p_restart_disarm_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hitOffset && !wrCtrl) |=> (!offArmBit && evtBit));
endmodule

// File: rtl/ptp_ns_timer.sv
module ptp_ns_timer
  import ptp_ns_timer_pkg::*;
#(
  parameter int TIME_W  = 32,
  parameter int INC_W   = 7,
  parameter int CORR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int WRAP_NS = 1_000_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  strb_t             strb;
  logic [TIME_W-1:0] loadVal, offsetVal, snapshot;
  logic [CORR_W-1:0] corrPeriod;
  logic [INC_W-1:0]  incNom, incCorr;
  logic              hitOffset, hitWrap;

  ptp_ns_timer_ctrl #(
    .TIME_W(TIME_W), .INC_W(INC_W), .CORR_W(CORR_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq), .strb(strb), .loadVal(loadVal),
    .offsetVal(offsetVal), .corrPeriod(corrPeriod), .incNom(incNom),
    .incCorr(incCorr), .hitOffset(hitOffset), .hitWrap(hitWrap),
    .snapshot(snapshot)
  );

  ptp_ns_timer_dp #(
    .TIME_W(TIME_W), .INC_W(INC_W), .CORR_W(CORR_W), .WRAP_NS(WRAP_NS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .offsetVal(offsetVal), .corrPeriod(corrPeriod), .incNom(incNom),
    .incCorr(incCorr), .hitOffset(hitOffset), .hitWrap(hitWrap),
    .snapshot(snapshot)
  );
endmodule

// File: tb/ptp_ns_timer_tb.sv
`timescale 1ns/1ps
module ptp_ns_timer_tb_top;
  localparam longint SEC  = 64'd1000000000;
  localparam longint MASK = 64'hFFFFFFFF;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [2:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        irq;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  int    curCtrl = 0;

  always #2 clk = ~clk;

  ptp_ns_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // behavioural reference model
  longint mCnt, mCorrCnt, mSnap, mOff, mCorrPer;
  int     mIncN, mIncC;
  bit     mRun, mArm, mOffRst, mIrqEn, mSecWrap, mCap, mEvt;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mCorrCnt = 0; mSnap = 0; mOff = 0; mCorrPer = 0;
      mIncN = 0; mIncC = 0;
      mRun = 0; mArm = 0; mOffRst = 0; mIrqEn = 0; mSecWrap = 0; mCap = 0; mEvt = 0;
    end else begin
      longint s, oldCnt;
      int     inc;
      bit     useC, loadT, hOff, hWrap, wCtrl;
      oldCnt = mCnt;
      useC   = (mCorrPer != 0) && (mCorrCnt >= mCorrPer - 1);
      inc    = useC ? mIncC : mIncN;
      s      = oldCnt + inc;
      loadT  = wrEn && addr == 3'd1;
      wCtrl  = wrEn && addr == 3'd0;
      hOff   = mRun && mArm && mOffRst && !loadT && oldCnt < mOff && s >= mOff;
      hWrap  = mRun && mSecWrap && !loadT && !hOff && s >= SEC;
      if (loadT)      mCnt = longint'(wrData);
      else if (hOff)  mCnt = 0;
      else if (hWrap) mCnt = s - SEC;
      else if (mRun)  mCnt = s & MASK;
      if (mRun) mCorrCnt = (useC || mCorrPer == 0) ? 0 : mCorrCnt + 1;
      if (mCap) mSnap = oldCnt;
      mCap = wCtrl && wrData[11];
      if (wCtrl) begin
        mRun = wrData[0]; mArm = wrData[2]; mOffRst = wrData[3];
        mIrqEn = wrData[4]; mSecWrap = wrData[5];
      end else if (hOff) mArm = 0;
      if (hOff || hWrap) mEvt = 1;
      else if (wrEn && addr == 3'd5 && wrData[15]) mEvt = 0;
      if (wrEn && addr == 3'd2) mOff = longint'(wrData);
      if (wrEn && addr == 3'd3) mCorrPer = longint'(wrData);
      if (wrEn && addr == 3'd4) begin
        mIncN = int'(wrData[6:0]); mIncC = int'(wrData[14:8]);
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [2:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      3'd0: begin
        v[0] = mRun; v[2] = mArm; v[3] = mOffRst; v[4] = mIrqEn;
        v[5] = mSecWrap; v[11] = mCap;
      end
      3'd1: v = mSnap[31:0];
      3'd2: v = mOff[31:0];
      3'd3: v = mCorrPer[31:0];
      3'd4: begin v[6:0] = mIncN[6:0]; v[14:8] = mIncC[6:0]; end
      3'd5: v[15] = mEvt;
      default: v = '0;
    endcase
    return v;
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      logic [31:0] e;
      e = expRead(addr);
      checks++;
      if (rdData !== e) begin
        errors++;
        $display("FAIL %s: read addr %0d got %h expected %h", curReq, addr, rdData, e);
      end
      checks++;
      if (irq !== (mEvt && mIrqEn)) begin
        errors++;
        $display("FAIL %s: irq got %b expected %b", curReq, irq, mEvt && mIrqEn);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic setCtrl(input int v);
    curCtrl = v;
    wr(3'd0, 32'(v));
  endtask

  task automatic captureRead();
    wr(3'd0, 32'(curCtrl | (1 << 11)));
    addr = 3'd0; idle(1);
    addr = 3'd1; idle(2);
  endtask

  bit done = 0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
    idle(3);
    rstN = 1'b1;

    curReq = "R1";
    for (int a = 0; a < 6; a++) begin addr = 3'(a); idle(1); end

    curReq = "R2";
    wr(3'd4, 32'd25);
    setCtrl(1);
    idle(10);
    captureRead();
    idle(5);

    curReq = "R3";
    wr(3'd3, 32'd4);
    wr(3'd4, 32'd25 | (32'd30 << 8));
    idle(13);
    captureRead();
    wr(3'd3, 32'd0);
    idle(7);
    captureRead();

    curReq = "R4";
    setCtrl(0);
    idle(5);
    wr(3'd4, 32'd3 | (32'd9 << 8));
    wr(3'd2, 32'd77);
    captureRead();
    idle(4);
    captureRead();
    addr = 3'd4; idle(1);

    curReq = "R5";
    wr(3'd1, 32'd1000);
    captureRead();
    setCtrl(1);
    idle(4);
    captureRead();

    curReq = "R8";
    wr(3'd1, 32'hFFFF_FFF0);
    idle(8);
    captureRead();
    addr = 3'd5; idle(1);

    curReq = "R7";
    setCtrl(1 | (1 << 5));
    wr(3'd4, 32'd25);
    wr(3'd1, 32'(SEC - 80));
    idle(6);
    addr = 3'd5; idle(1);
    captureRead();

    curReq = "R10";
    setCtrl(1 | (1 << 4) | (1 << 5));
    addr = 3'd5; idle(2);
    wr(3'd5, 32'd0);
    addr = 3'd5; idle(2);
    wr(3'd5, 32'd1 << 15);
    addr = 3'd5; idle(2);

    curReq = "R9";
    wr(3'd2, 32'd500);
    wr(3'd1, 32'd300);
    setCtrl(1 | 4 | 8 | 16 | 32);
    addr = 3'd0; idle(12);
    captureRead();
    addr = 3'd5; idle(1);
    wr(3'd5, 32'd1 << 15);
    curCtrl = 1 | 8 | 16 | 32;
    wr(3'd1, 32'd600);
    setCtrl(1 | 4 | 8 | 16 | 32);
    idle(6);
    addr = 3'd5; idle(1);
    captureRead();

    curReq = "R11";
    setCtrl(1 | (1 << 5));
    wr(3'd1, 32'd5000);
    captureRead();
    wr(3'd1, 32'(SEC - 5));
    captureRead();
    idle(3);
    captureRead();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule